// File: doc/BRIEF.md
# Soft Mute Fader with Silence Detector

This block sits on a stereo sample stream that advances one frame per `frame_tick` pulse. It scales both signed channels by a common gain that moves in linear steps between unity and full silence under the `mute_req` input. The gain moves one step per frame, so a complete fade takes `RAMP_STEPS` frames in either direction. If the request flips while a fade is running, the gain turns around at its present value. It never jumps back to an endpoint.

Next to the fader, a silence detector counts frames in which both input channels are exactly zero. After a long unbroken run it raises `zero_flag`. The flag drops on the first frame that carries any nonzero input. Frames without a tick neither extend nor break the run, and they change nothing else in the block.

Top module: `sample_fade_guard`

## Requirements
- R1: While reset is held and just after it, both outputs are zero, `zero_flag` is low and the gain is unity.
- R2: On each tick with `mute_req` high and a gain above zero, the gain drops by one step of 1/RAMP_STEPS. Starting from unity, it reaches zero after RAMP_STEPS (default 1024) ticks.
- R3: On each tick with `mute_req` low and a gain below unity, the gain rises by one step. Starting from zero, it reaches unity after RAMP_STEPS ticks.
- R4: When `mute_req` changes mid-fade, the gain reverses from its current value. Getting back to the starting end takes exactly as many ticks as have elapsed since the fade began.
- R5: On each tick, each output is registered as input × g / RAMP_STEPS, where g is the gain before that tick's step. The result is rounded toward zero, in two's complement. At unity the sample passes through unchanged.
- R6: When the gain is zero at a tick, both outputs become exactly zero, whatever the sign of the input.
- R7: On cycles without `frame_tick`, the gain, both outputs and `zero_flag` keep their values.
- R8: `zero_flag` goes high on the tick that completes ZERO_RUN (default 8192) consecutive frames in which both channels are zero. It does not go high one frame earlier.
- R9: `zero_flag` goes low on any tick where either channel is nonzero, and the zero run starts again from nothing.
- R10: Once `zero_flag` is high, it stays high for as long as zero frames continue past ZERO_RUN, because the run count saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse marking a new stereo frame |
| mute_req | input | 1 | High asks for fade to silence, low for fade to unity |
| left_in | input | SAMPLE_W | Signed left sample |
| right_in | input | SAMPLE_W | Signed right sample |
| left_out | output | SAMPLE_W | Scaled left sample, registered |
| right_out | output | SAMPLE_W | Scaled right sample, registered |
| zero_flag | output | 1 | High after a long joint run of zero input |

## Verification
Every result lands one clock edge after the tick that produces it. The outputs use the gain as it stood before the tick, and the flag reflects the frame that was just accepted. The bench drives inputs on the falling edge, pulses the tick for one cycle, and compares all three outputs on the next falling edge against a bench model that it steps once per tick. The gain cannot be seen directly, so it is read through the outputs by using an input of 2^22, which yields exactly 4096 × gain. Idle cycles between ticks are checked for held values.

// File: rtl/fade_pkg.sv
package fade_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_DOWN = 2'd1,
      STEP_UP   = 2'd2
   } step_dir_t;
endpackage

// File: rtl/fade_gain_ramp.sv
module fade_gain_ramp
   import fade_pkg::*;
#(
   parameter int RAMP_STEPS = 1024,
   localparam int GAIN_W    = $clog2(RAMP_STEPS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              mute_req,
   output logic [GAIN_W-1:0] gain_q
);
   localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(RAMP_STEPS);

   step_dir_t dir;

   always_comb begin
      dir = STEP_HOLD;
      if (frame_tick) begin
         if (mute_req && gain_q != '0)
            dir = STEP_DOWN;
         else if (!mute_req && gain_q != UNITY)
            dir = STEP_UP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         gain_q <= UNITY;
      else begin
         case (dir)
            STEP_DOWN: gain_q <= gain_q - 1'b1;
            STEP_UP:   gain_q <= gain_q + 1'b1;
            default:   gain_q <= gain_q;
         endcase
      end
   end
endmodule

// File: rtl/fade_scaler.sv
module fade_scaler #(
   parameter int SAMPLE_W = 24,
   parameter int GAIN_W   = 11,
   parameter int SHIFT    = 10
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [GAIN_W-1:0]   gain,
   output logic [SAMPLE_W-1:0] scaled
);
   localparam int PW = SAMPLE_W + GAIN_W + 1;
   localparam logic [PW-1:0] BIAS = {{(PW-SHIFT){1'b0}}, {SHIFT{1'b1}}};

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;
   logic signed [PW-1:0] shifted;

   always_comb begin
      prod    = $signed(sample) * $signed({1'b0, gain});
      biased  = prod[PW-1] ? (prod + $signed(BIAS)) : prod;
      shifted = biased >>> SHIFT;
      scaled  = shifted[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/zero_run_watch.sv
module zero_run_watch #(
   parameter int RUN_LEN = 8192,
   localparam int CW     = $clog2(RUN_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   input  logic frame_silent,
   output logic flag_q
);
   localparam logic [CW-1:0] LIMIT    = CW'(RUN_LEN);
   localparam logic [CW-1:0] LAST_ONE = CW'(RUN_LEN - 1);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         flag_q <= 1'b0;
      end else if (frame_tick) begin
         if (!frame_silent) begin
            run_q  <= '0;
            flag_q <= 1'b0;
         end else begin
            if (run_q != LIMIT)
               run_q <= run_q + 1'b1;
            flag_q <= (run_q >= LAST_ONE);
         end
      end
   end
endmodule

// File: rtl/sample_fade_guard.sv
module sample_fade_guard #(
   parameter int SAMPLE_W   = 24,
   parameter int RAMP_STEPS = 1024,
   parameter int ZERO_RUN   = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_tick,
   input  logic                mute_req,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic [SAMPLE_W-1:0] left_out,
   output logic [SAMPLE_W-1:0] right_out,
   output logic                zero_flag
);
   localparam int GAIN_W = $clog2(RAMP_STEPS) + 1;
   localparam int SHIFT  = $clog2(RAMP_STEPS);
   localparam int NCH    = 2;

   generate
      if ((RAMP_STEPS & (RAMP_STEPS - 1)) != 0 || RAMP_STEPS < 2) begin : bad_ramp
         $error("RAMP_STEPS must be a power of two of at least 2");
      end
      if (SAMPLE_W < 2) begin : bad_width
         $error("SAMPLE_W must be at least 2");
      end
      if (ZERO_RUN < 2) begin : bad_run
         $error("ZERO_RUN must be at least 2");
      end
   endgenerate

   logic [GAIN_W-1:0]              gain_q;
   logic [NCH-1:0][SAMPLE_W-1:0]   ch_in;
   logic [NCH-1:0][SAMPLE_W-1:0]   ch_scaled;
   logic [NCH-1:0][SAMPLE_W-1:0]   ch_q;

   assign ch_in[0] = left_in;
   assign ch_in[1] = right_in;

   fade_gain_ramp #(.RAMP_STEPS(RAMP_STEPS)) ramp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .mute_req   (mute_req),
      .gain_q     (gain_q)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      fade_scaler #(
         .SAMPLE_W (SAMPLE_W),
         .GAIN_W   (GAIN_W),
         .SHIFT    (SHIFT)
      ) scale_i (
         .sample (ch_in[ch]),
         .gain   (gain_q),
         .scaled (ch_scaled[ch])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)
            ch_q[ch] <= '0;
         else if (frame_tick)
            ch_q[ch] <= ch_scaled[ch];
      end
   end

   assign left_out  = ch_q[0];
   assign right_out = ch_q[1];

   zero_run_watch #(.RUN_LEN(ZERO_RUN)) zero_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_tick   (frame_tick),
      .frame_silent ((left_in == '0) && (right_in == '0)),
      .flag_q       (zero_flag)
   );
endmodule

// File: rtl/sample_fade_guard_chk.sv
module sample_fade_guard_chk #(
   parameter int SAMPLE_W   = 24,
   parameter int RAMP_STEPS = 1024,
   localparam int GAIN_W    = $clog2(RAMP_STEPS) + 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_tick,
   input logic                mute_req,
   input logic [SAMPLE_W-1:0] left_in,
   input logic [SAMPLE_W-1:0] right_in,
   input logic [SAMPLE_W-1:0] left_out,
   input logic [SAMPLE_W-1:0] right_out,
   input logic                zero_flag,
   input logic [GAIN_W-1:0]   gain_q
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!zero_flag && left_out == '0 && right_out == '0));

   // R2
   gain_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && mute_req && gain_q != '0) |=> gain_q == $past(gain_q) - 1'b1);

   // R3
   gain_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !mute_req && gain_q != GAIN_W'(RAMP_STEPS)) |=> gain_q == $past(gain_q) + 1'b1);

   // R3
   gain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gain_q <= GAIN_W'(RAMP_STEPS));

   // R6
   full_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && gain_q == '0) |=> (left_out == '0 && right_out == '0));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> ($stable(gain_q) && $stable(left_out) && $stable(right_out) && $stable(zero_flag)));

   // R9
   flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && (left_in != '0 || right_in != '0)) |=> !zero_flag);

   // R10
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && zero_flag && left_in == '0 && right_in == '0) |=> zero_flag);
endmodule

bind sample_fade_guard sample_fade_guard_chk #(
   .SAMPLE_W   (SAMPLE_W),
   .RAMP_STEPS (RAMP_STEPS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_tick (frame_tick),
   .mute_req   (mute_req),
   .left_in    (left_in),
   .right_in   (right_in),
   .left_out   (left_out),
   .right_out  (right_out),
   .zero_flag  (zero_flag),
   .gain_q     (gain_q)
);

// File: tb/sample_fade_guard_tb_top.sv
module sample_fade_guard_tb_top;
   localparam int SW    = 24;
   localparam int STEPS = 1024;
   localparam int RUN   = 8192;
   localparam int PROBE = 1 << 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_tick = 1'b0;
   logic          mute_req = 1'b0;
   logic [SW-1:0] left_in = '0;
   logic [SW-1:0] right_in = '0;
   logic [SW-1:0] left_out;
   logic [SW-1:0] right_out;
   logic          zero_flag;

   int checks = 0;
   int fails  = 0;
   int m_gain = STEPS;
   int m_run  = 0;
   int exp_l  = 0;
   int exp_r  = 0;
   bit exp_f  = 1'b0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   sample_fade_guard #(.SAMPLE_W(SW), .RAMP_STEPS(STEPS), .ZERO_RUN(RUN)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mute_req(mute_req),
      .left_in(left_in), .right_in(right_in),
      .left_out(left_out), .right_out(right_out), .zero_flag(zero_flag)
   );

   function automatic int scale(int s, int g);
      longint p = longint'(s) * longint'(g);
      if (p < 0) return -int'((-p) / STEPS);
      return int'(p / STEPS);
   endfunction

   task automatic check(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic compare_all(string tag);
      check($signed(left_out) == exp_l, tag, $signed(left_out), exp_l);
      check($signed(right_out) == exp_r, tag, $signed(right_out), exp_r);
      check(zero_flag == exp_f, tag, int'(zero_flag), int'(exp_f));
   endtask

   task automatic frame(int l, int r, bit m, string tag);
      @(negedge clk);
      left_in = SW'(l); right_in = SW'(r); mute_req = m; frame_tick = 1'b1;
      exp_l = scale(l, m_gain);
      exp_r = scale(r, m_gain);
      if (l == 0 && r == 0) begin
         exp_f = (m_run >= RUN - 1);
         if (m_run < RUN) m_run++;
      end else begin
         exp_f = 1'b0;
         m_run = 0;
      end
      if (m && m_gain > 0) m_gain--;
      else if (!m && m_gain < STEPS) m_gain++;
      @(negedge clk);
      frame_tick = 1'b0;
      compare_all(tag);
   endtask

   function automatic int rnd_sample();
      return $signed(SW'($urandom()));
   endfunction

   initial begin
      #(8 * 200000);
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd4711);
      left_in = 24'h123456; right_in = 24'h654321;
      repeat (3) @(negedge clk);
      // R1: outputs and flag quiet in reset
      compare_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");
      // R1: gain starts at unity
      frame(PROBE, -PROBE, 1'b0, "R1");
      check($signed(left_out) == PROBE, "R1", $signed(left_out), PROBE);

      // R5: unity pass-through with random samples, plus extremes
      for (int i = 0; i < 20; i++) frame(rnd_sample(), rnd_sample(), 1'b0, "R5");
      frame(-(1 << 23), (1 << 23) - 1, 1'b0, "R5");

      // R7: idle cycles hold everything
      left_in = 24'h0F0F0F; right_in = 24'h00000F; mute_req = 1'b1;
      repeat (5) @(negedge clk);
      compare_all("R7");

      // R2: fade down from unity with probe sample; random mid-ramp scaling for R5
      for (int i = 0; i < 300; i++) frame(PROBE, PROBE, 1'b1, "R2");
      check($signed(left_out) == 4096 * 725, "R2", $signed(left_out), 4096 * 725);
      for (int i = 0; i < 200; i++) frame(rnd_sample(), rnd_sample(), 1'b1, "R5");
      frame(-1023, 1023, 1'b1, "R5");
      for (int i = 0; i < 523; i++) frame(PROBE, -PROBE, 1'b1, "R2");
      // R6: gain now zero; any sample yields zero
      for (int i = 0; i < 10; i++) frame(rnd_sample() | 1, -(1 << 23), 1'b1, "R6");
      check(left_out == '0 && right_out == '0, "R6", $signed(left_out), 0);

      // R4: release 300 ticks then mute again; returns to zero after 300 more
      for (int i = 0; i < 300; i++) frame(PROBE, PROBE, 1'b0, "R4");
      for (int i = 0; i < 299; i++) frame(PROBE, PROBE, 1'b1, "R4");
      frame(PROBE, PROBE, 1'b1, "R4");
      check($signed(left_out) == 4096, "R4", $signed(left_out), 4096);
      frame(PROBE, PROBE, 1'b1, "R4");
      check(left_out == '0, "R4", $signed(left_out), 0);

      // R3: full rise to unity; R4 reversal from the top side too
      for (int i = 0; i < STEPS; i++) frame(PROBE, PROBE, 1'b0, "R3");
      frame(PROBE, PROBE, 1'b0, "R3");
      check($signed(left_out) == PROBE, "R3", $signed(left_out), PROBE);
      for (int i = 0; i < 40; i++) frame(PROBE, PROBE, 1'b1, "R4");
      for (int i = 0; i < 40; i++) frame(PROBE, PROBE, 1'b0, "R4");
      frame(PROBE, PROBE, 1'b0, "R4");
      check($signed(left_out) == PROBE, "R4", $signed(left_out), PROBE);

      // R8: joint zero run, flag rises only on the completing tick
      for (int i = 0; i < RUN - 1; i++) frame(0, 0, 1'b0, "R8");
      check(zero_flag == 1'b0, "R8", int'(zero_flag), 0);
      left_in = '0; right_in = '0;
      repeat (4) @(negedge clk);
      compare_all("R7");
      frame(0, 0, 1'b0, "R8");
      check(zero_flag == 1'b1, "R8", int'(zero_flag), 1);
      // R10: stays high past the limit
      for (int i = 0; i < 50; i++) frame(0, 0, 1'b0, "R10");
      check(zero_flag == 1'b1, "R10", int'(zero_flag), 1);
      // R9: a single nonzero channel drops it
      frame(0, -1, 1'b0, "R9");
      check(zero_flag == 1'b0, "R9", int'(zero_flag), 0);
      for (int i = 0; i < RUN - 1; i++) frame(0, 0, 1'b0, "R9");
      frame(5, 0, 1'b0, "R9");
      check(zero_flag == 1'b0, "R9", int'(zero_flag), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule